// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in several privileged operating modes. A number of the upper registers have private shadow copies per mode, and which copy a read or write reaches is chosen by the current 5-bit mode code. The core gets two combinational read ports, one synchronous write port and a mode-load port. Banking is done by steering each access to the right physical register. Nothing is copied when the mode changes, so a change of mode cannot lose a shadowed value.

There are 31 physical registers. Sixteen are shared. The fast-interrupt mode has seven private registers that replace R8 to R14. The interrupt, supervisor, abort and undefined modes each have a private pair that replaces R13 and R14. An optional side input forces all three ports onto the shared copies, so a privileged mode can reach user registers.

Top module: `mode_banked_regfile`

## Requirements
- R1: An active-low asynchronous reset clears every physical register to zero and sets the current mode to supervisor (code 0x13).
- R2: Both read ports are combinational and return the value of the copy that the current mode selects. A write is visible on a read port in the cycle after its clock edge.
- R3: In mode code 0x11 (fast interrupt), R8 to R14 reach seven registers private to that mode.
- R4: In mode codes 0x12, 0x13, 0x17 and 0x1B, R13 and R14 reach a pair private to that mode. R8 to R12 stay shared in these modes.
- R5: Every other mode code reaches the shared copies of R0 to R14. This covers 0x10, 0x1F and codes that are not defined.
- R6: R0 to R7 and R15 have a single copy that every mode reaches.
- R7: A value written in one mode reads back unchanged after a switch to another mode and back again.
- R8: The mode register loads mode_i only at a clock edge with mode_we_i high, and otherwise holds its value. Loading the mode that is already active changes no visible register.
- R9: A write in the same cycle as a mode load goes to the bank of the mode that was active at the start of that cycle.
- R10: While usr_force_i is high, both reads and the write reach the shared copies, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Load mode_i into the mode register |
| mode_i | input | 5 | New mode code |
| mode_o | output | 5 | Current mode code |
| usr_force_i | input | 1 | Steer all ports to the shared copies |
| ra_idx_i | input | 4 | Read port A register index |
| ra_data_o | output | 32 | Read port A data |
| rb_idx_i | input | 4 | Read port B register index |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wa_idx_i | input | 4 | Write register index |
| wd_i | input | 32 | Write data |

## Verification
A table writes distinct values to R3, R8, R12, R13, R14 and R15 from the user, fast, interrupt, supervisor, abort, undefined and system modes. It then reads every one of them back from each mode, and also from an undefined mode code. A read of R14 that stays zero in fast mode shows the private bank is separate. A read of R8 written from interrupt mode that shows up in user mode shows R8 to R12 are shared outside fast mode. A read of R13 that differs between the supervisor and abort pairs shows the pairs do not alias.

Directed cases then cover:
- a write that lands in the same cycle as a mode load;
- a reload of the mode already active;
- a change on mode_i without its load strobe;
- forced shared access from fast mode;
- a reset in the middle of the run.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;
  localparam int DATA_W    = 32;
  localparam int MODE_W    = 5;
  localparam int NUM_ARCH  = 16;
  localparam int AIDX_W    = $clog2(NUM_ARCH);
  localparam int FAST_LO   = 8;
  localparam int FAST_HI   = 14;
  localparam int FAST_CNT  = FAST_HI - FAST_LO + 1;
  localparam int PAIR_LO   = 13;
  localparam int PAIR_CNT  = 2;
  localparam int PAIR_MODES = 4;
  localparam int FAST_BASE = NUM_ARCH;
  localparam int PAIR_BASE = FAST_BASE + FAST_CNT;
  localparam int NUM_PHYS  = PAIR_BASE + PAIR_MODES * PAIR_CNT;
  localparam int PIDX_W    = $clog2(NUM_PHYS);

  localparam logic [MODE_W-1:0] MODE_FAST = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ  = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC  = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT  = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND  = 5'h1B;

  // pair banks must stay contiguous after BK_IRQ
  typedef enum logic [2:0] {
    BK_SHARED = 3'd0,
    BK_FAST   = 3'd1,
    BK_IRQ    = 3'd2,
    BK_SVC    = 3'd3,
    BK_ABT    = 3'd4,
    BK_UND    = 3'd5
  } bank_e;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    bank_e b;
    unique case (m)
      MODE_FAST: b = BK_FAST;
      MODE_IRQ:  b = BK_IRQ;
      MODE_SVC:  b = BK_SVC;
      MODE_ABT:  b = BK_ABT;
      MODE_UND:  b = BK_UND;
      default:   b = BK_SHARED;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/mbrf_mode.sv
module mbrf_mode
  import mbrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] mode_o,
  output bank_e             bank_o
);
  logic [MODE_W-1:0] mode_q;
  bank_e             bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SVC;
      bank_q <= BK_SVC;
    end else if (we_i) begin
      mode_q <= mode_i;
      bank_q <= bank_of(mode_i);
    end
  end

  assign mode_o = mode_q;
  assign bank_o = bank_q;
endmodule

// File: rtl/mbrf_map.sv
module mbrf_map
  import mbrf_pkg::*;
(
  input  bank_e             bank_i,
  input  logic [AIDX_W-1:0] idx_i,
  output logic [PIDX_W-1:0] phys_o
);
  int unsigned a;
  int unsigned p;
  logic        in_fast;
  logic        in_pair;
  logic        pair_bank;

  always_comb begin
    a         = int'(idx_i);
    in_fast   = (a >= FAST_LO) && (a <= FAST_HI);
    in_pair   = (a >= PAIR_LO) && (a < PAIR_LO + PAIR_CNT);
    pair_bank = (bank_i == BK_IRQ) || (bank_i == BK_SVC) ||
                (bank_i == BK_ABT) || (bank_i == BK_UND);
    p = a;
    if (bank_i == BK_FAST && in_fast)
      p = FAST_BASE + a - FAST_LO;
    else if (pair_bank && in_pair)
      p = PAIR_BASE + (int'(bank_i) - int'(BK_IRQ)) * PAIR_CNT + a - PAIR_LO;
    phys_o = PIDX_W'(p);
  end
endmodule

// File: rtl/mbrf_store.sv
module mbrf_store
  import mbrf_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int DEPTH = NUM_PHYS,
  parameter int AW    = PIDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q[g] <= '0;
      else if (we_i && (waddr_i == AW'(g)))         q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr_a_i == AW'(i)) rdata_a_o = q[i];
      if (raddr_b_i == AW'(i)) rdata_b_o = q[i];
    end
  end
endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import mbrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] mode_o,
  input  logic              usr_force_i,
  input  logic [AIDX_W-1:0] ra_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [AIDX_W-1:0] rb_idx_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [AIDX_W-1:0] wa_idx_i,
  input  logic [DATA_W-1:0] wd_i
);
  localparam int NPORT = 3;

  bank_e                          cur_bank;
  bank_e                          eff_bank;
  logic [NPORT-1:0][AIDX_W-1:0]   arch_idx;
  logic [NPORT-1:0][PIDX_W-1:0]   phys_idx;

  mbrf_mode u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mode_we_i),
    .mode_i (mode_i),
    .mode_o (mode_o),
    .bank_o (cur_bank)
  );

  // write uses the registered mode, so a same-cycle mode load is not seen yet
  assign eff_bank = usr_force_i ? BK_SHARED : cur_bank;
  assign arch_idx = {wa_idx_i, rb_idx_i, ra_idx_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    mbrf_map u_map (
      .bank_i (eff_bank),
      .idx_i  (arch_idx[p]),
      .phys_o (phys_idx[p])
    );
  end

  mbrf_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .waddr_i   (phys_idx[2]),
    .wdata_i   (wd_i),
    .raddr_a_i (phys_idx[0]),
    .raddr_b_i (phys_idx[1]),
    .rdata_a_o (ra_data_o),
    .rdata_b_o (rb_data_o)
  );
endmodule

// File: rtl/mode_banked_regfile_chk.sv
module mode_banked_regfile_chk
  import mbrf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_we_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [MODE_W-1:0] mode_o,
  input logic              usr_force_i,
  input logic [AIDX_W-1:0] ra_idx_i,
  input logic [DATA_W-1:0] ra_data_o,
  input logic [AIDX_W-1:0] rb_idx_i,
  input logic [DATA_W-1:0] rb_data_o,
  input logic              we_i,
  input logic [AIDX_W-1:0] wa_idx_i,
  input logic [DATA_W-1:0] wd_i
);
  p_hold_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_o));

  p_load_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> mode_o == $past(mode_i));

  p_read_after_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mode_we_i && !usr_force_i) ##1
    (!usr_force_i && ra_idx_i == $past(wa_idx_i)) |-> ra_data_o == $past(wd_i));

  p_pc_unbanked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_idx_i == 4'd15) ##1 (ra_idx_i == 4'd15) |-> ra_data_o == $past(wd_i));

  p_low_unbanked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_idx_i < 4'd8) ##1 (rb_idx_i == $past(wa_idx_i)) |-> rb_data_o == $past(wd_i));

  p_ports_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_idx_i == rb_idx_i |-> ra_data_o == rb_data_o);
endmodule

bind mode_banked_regfile mode_banked_regfile_chk u_chk (.*);

// File: tb/mode_banked_regfile_bench.sv
module mode_banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_we_i = 1'b0;
  logic [4:0]  mode_i = '0;
  logic [4:0]  mode_o;
  logic        usr_force_i = 1'b0;
  logic [3:0]  ra_idx_i = '0;
  logic [31:0] ra_data_o;
  logic [3:0]  rb_idx_i = '0;
  logic [31:0] rb_data_o;
  logic        we_i = 1'b0;
  logic [3:0]  wa_idx_i = '0;
  logic [31:0] wd_i = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mode_banked_regfile u_mode_banked_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_i(mode_i),
    .mode_o(mode_o), .usr_force_i(usr_force_i),
    .ra_idx_i(ra_idx_i), .ra_data_o(ra_data_o),
    .rb_idx_i(rb_idx_i), .rb_data_o(rb_data_o),
    .we_i(we_i), .wa_idx_i(wa_idx_i), .wd_i(wd_i)
  );

  typedef struct packed {
    logic        rd;
    logic [4:0]  mode;
    logic [3:0]  idx;
    logic [31:0] val;
  } step_t;

  localparam int NSTEP = 38;
  localparam step_t TBL [NSTEP] = '{
    '{1'b0, 5'h10, 4'd8,  32'hA08}, '{1'b0, 5'h10, 4'd13, 32'hA0D},
    '{1'b0, 5'h10, 4'd14, 32'hA0E}, '{1'b0, 5'h10, 4'd3,  32'hA03},
    '{1'b0, 5'h10, 4'd15, 32'hA0F},
    '{1'b0, 5'h11, 4'd8,  32'hB08}, '{1'b0, 5'h11, 4'd12, 32'hB0C},
    '{1'b0, 5'h11, 4'd13, 32'hB0D},
    '{1'b0, 5'h12, 4'd13, 32'hC0D}, '{1'b0, 5'h12, 4'd8,  32'hC08},
    '{1'b0, 5'h13, 4'd14, 32'hD0E},
    '{1'b0, 5'h17, 4'd13, 32'hE0D},
    '{1'b0, 5'h1B, 4'd14, 32'hF0E},
    '{1'b0, 5'h1F, 4'd13, 32'h90D},
    '{1'b1, 5'h10, 4'd8,  32'hC08}, '{1'b1, 5'h10, 4'd13, 32'h90D},
    '{1'b1, 5'h10, 4'd14, 32'hA0E}, '{1'b1, 5'h10, 4'd3,  32'hA03},
    '{1'b1, 5'h10, 4'd15, 32'hA0F},
    '{1'b1, 5'h11, 4'd8,  32'hB08}, '{1'b1, 5'h11, 4'd12, 32'hB0C},
    '{1'b1, 5'h11, 4'd13, 32'hB0D}, '{1'b1, 5'h11, 4'd14, 32'h0},
    '{1'b1, 5'h11, 4'd3,  32'hA03}, '{1'b1, 5'h11, 4'd15, 32'hA0F},
    '{1'b1, 5'h12, 4'd13, 32'hC0D}, '{1'b1, 5'h12, 4'd14, 32'h0},
    '{1'b1, 5'h12, 4'd8,  32'hC08},
    '{1'b1, 5'h13, 4'd13, 32'h0},   '{1'b1, 5'h13, 4'd14, 32'hD0E},
    '{1'b1, 5'h13, 4'd8,  32'hC08},
    '{1'b1, 5'h17, 4'd13, 32'hE0D}, '{1'b1, 5'h17, 4'd14, 32'h0},
    '{1'b1, 5'h1B, 4'd13, 32'h0},   '{1'b1, 5'h1B, 4'd14, 32'hF0E},
    '{1'b1, 5'h1F, 4'd13, 32'h90D}, '{1'b1, 5'h1F, 4'd12, 32'h0},
    '{1'b1, 5'h05, 4'd13, 32'h90D}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk);
    mode_we_i = 1'b1; mode_i = m;
    @(negedge clk);
    mode_we_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] v);
    @(negedge clk);
    we_i = 1'b1; wa_idx_i = idx; wd_i = v;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk);
    ra_idx_i = idx; rb_idx_i = idx;
    #1;
    va = ra_data_o; vb = rb_data_o;
  endtask

  function automatic string tag_of(input logic [4:0] m, input logic [3:0] idx);
    if (idx < 4'd8 || idx == 4'd15) return "R6/R7";
    if (m == 5'h11) return "R3/R7";
    if (m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B) return "R4/R7";
    return "R5/R7";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] va, vb;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    #1;
    chk("R1 mode", {27'd0, mode_o}, 32'h13);
    rd(4'd0, va, vb);  chk("R1 r0", va, 32'h0);
    rd(4'd13, va, vb); chk("R1 r13", va, 32'h0);

    // table: writes then read-back from every mode
    for (int i = 0; i < NSTEP; i++) begin
      if (mode_o != TBL[i].mode) set_mode(TBL[i].mode);
      if (!TBL[i].rd) wr(TBL[i].idx, TBL[i].val);
      else begin
        rd(TBL[i].idx, va, vb);
        chk(tag_of(TBL[i].mode, TBL[i].idx), va, TBL[i].val);
        chk("R2 port b", vb, TBL[i].val);
      end
    end

    // R9 write in same cycle as mode load goes to old bank (irq)
    set_mode(5'h12);
    @(negedge clk);
    we_i = 1'b1; wa_idx_i = 4'd13; wd_i = 32'h111;
    mode_we_i = 1'b1; mode_i = 5'h13;
    @(negedge clk);
    we_i = 1'b0; mode_we_i = 1'b0;
    chk("R8 mode loaded", {27'd0, mode_o}, 32'h13);
    rd(4'd13, va, vb); chk("R9 svc r13 untouched", va, 32'h0);
    set_mode(5'h12);
    rd(4'd13, va, vb); chk("R9/R7 irq r13", va, 32'h111);

    // R8 reload of same mode, and mode_i without strobe
    set_mode(5'h12);
    rd(4'd13, va, vb); chk("R8 same-mode reload", va, 32'h111);
    @(negedge clk); mode_i = 5'h11;
    @(negedge clk); #1;
    chk("R8 no strobe", {27'd0, mode_o}, 32'h12);

    // R10 forced shared access from fast mode
    set_mode(5'h11);
    usr_force_i = 1'b1;
    rd(4'd8, va, vb); chk("R10 forced read r8", va, 32'hC08);
    wr(4'd9, 32'h222);
    usr_force_i = 1'b0;
    rd(4'd9, va, vb); chk("R10 fast r9 private", va, 32'h0);
    rd(4'd8, va, vb); chk("R3 fast r8", va, 32'hB08);
    set_mode(5'h10);
    rd(4'd9, va, vb); chk("R10 shared r9", va, 32'h222);

    // R1 mid-run reset
    @(negedge clk); rst_ni = 1'b0;
    #1;
    chk("R1 reset mode", {27'd0, mode_o}, 32'h13);
    rd(4'd15, va, vb); chk("R1 reset r15", va, 32'h0);
    @(negedge clk); rst_ni = 1'b1;
    set_mode(5'h11);
    rd(4'd8, va, vb); chk("R1 reset fast r8", va, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule